// File: doc/BRIEF.md
# Tracker Event Stream Sequencer

The sequencer plays back a compact music score held in memory. A tempo generator turns a programmed beats-per-minute value into eight tick pulses per beat. Each tick releases one period of the score. The parser reads that period's bytes through a one-cycle-latency read port and emits one key-on or key-off event per channel on a valid/ready output. A synthesizer driver downstream turns those events into register writes.

The score is a byte stream. The upper nibble of each command byte is the opcode and the lower nibble is a channel number. Opcode F opens a period. Opcode E is a key-on and is followed by one data byte, whose upper nibble is the note (1 to 7) and whose lower nibble is the octave (0 to 7). Opcode D is a key-off. Opcode C ends the song. Within one period, channels 0 to 13 must appear in strictly rising order. A malformed stream stops playback with a sticky error flag. A tick that arrives while a period is still being parsed is remembered and served later, and it sets a sticky overrun flag.

Top module: `trk_seq`

## Requirements
- R1: The tempo accumulator is cleared while `play` is low. On every clock edge with `play` high it adds `tempo_bpm`×8. When the sum reaches 60×CLK_HZ, the limit is subtracted and `tick` is high for the next cycle, so any remainder carries forward.
- R2: While `play` is low, or in reset, `ev_valid`, `rd_en`, `tick`, `done`, `err` and `overrun` are all 0. Raising `play` restarts the score from address 0.
- R3: The parser reads no byte until a tick is available. At the head of a period it consumes one opcode-F byte, whose lower nibble is ignored. It then parses until it meets the next opcode-F byte, which it leaves unread until the next tick. No event of period n is offered before the n-th tick.
- R4: A byte 0xEc followed by a data byte 0xNO produces one event with `ev_on`=1, `ev_chan`=c, `ev_note`=N and `ev_oct`=O.
- R5: A byte 0xDc produces one event with `ev_on`=0, `ev_chan`=c, `ev_note`=0 and `ev_oct`=0.
- R6: An opcode-C byte sets `done`. After that no event is emitted and no read is issued until `play` goes low.
- R7: The following set a sticky `err` and halt playback with no further events or reads: opcodes 0x0 to 0xB; a first byte of a period that is neither F nor C; a channel above 13; a channel not strictly above the previous channel of the same period; a note of 0 or above 7; an octave above 7. `done` and `err` are never both set.
- R8: While `ev_valid` is high and `ev_ready` is low, the event fields stay stable and no read is issued. An event is accepted on a clock edge where both are high.
- R9: A tick that arrives while a period is being parsed sets a sticky `overrun` flag. Up to 2^PEND_W−1 such ticks are counted, and each one later releases one period with no new tick needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play | input | 1 | High to play; low clears all playback state |
| tempo_bpm | input | BPM_W | Tempo in beats per minute |
| rd_en | output | 1 | Score memory read strobe |
| rd_addr | output | AW | Score memory byte address |
| rd_data | input | 8 | Score byte, valid one cycle after `rd_en` |
| ev_valid | output | 1 | Event offered |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_on | output | 1 | 1 key-on, 0 key-off |
| ev_chan | output | 4 | Channel number |
| ev_note | output | 3 | Note 1..7 (0 on key-off) |
| ev_oct | output | 3 | Octave 0..7 (0 on key-off) |
| tick | output | 1 | One-cycle tempo tick (eighth of a beat) |
| done | output | 1 | End marker reached (sticky) |
| err | output | 1 | Malformed stream (sticky) |
| overrun | output | 1 | Tick arrived during parsing (sticky) |

## Verification
A mixed score with empty periods, channel 13 and both opcodes is first played at a slow tempo with the consumer always ready. This separates tick gating and field decoding from backpressure effects. The same score is then replayed at a fast tempo with random readiness, which exercises payload hold under stalls.

A stall scenario keeps ready low while ticks pile up, then stops the tempo. The number of periods delivered afterwards shows whether queued ticks were kept or dropped. One short score per malformation shows which rule caught it and that no event escapes afterwards. A score that starts with the end marker, and a playback aborted mid-song and then restarted, cover the end-of-song handling and the restart from address 0.

// File: rtl/trk_pkg.sv
package trk_pkg;

    localparam int NIB = 4;

    localparam logic [NIB-1:0] OP_MARK = 4'hF;
    localparam logic [NIB-1:0] OP_ON   = 4'hE;
    localparam logic [NIB-1:0] OP_OFF  = 4'hD;
    localparam logic [NIB-1:0] OP_END  = 4'hC;

    localparam logic [NIB-1:0] NOTE_MAX = 4'd7;
    localparam logic [NIB-1:0] OCT_MAX  = 4'd7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_FETCH,
        S_RECV,
        S_NFETCH,
        S_NRECV,
        S_EMIT,
        S_STOP
    } prs_state_t;

    typedef struct packed {
        logic           on;
        logic [NIB-1:0] chan;
        logic [2:0]     note;
        logic [2:0]     oct;
    } trk_ev_t;

endpackage

// File: rtl/trk_tempo.sv
module trk_tempo #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BPM_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [BPM_W-1:0] bpm,
    output logic             tick
);
    localparam longint unsigned LIMIT = 64'd60 * 64'(CLK_HZ);
    localparam int ACC_W = $clog2(LIMIT + (64'd1 << (BPM_W + 3))) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } tempo_s;

    tempo_s q, d;
    logic [ACC_W-1:0] sum;

    always_comb begin
        d   = q;
        sum = q.acc + ACC_W'({bpm, 3'b000});
        if (!run) begin
            d.acc  = '0;
            d.tick = 1'b0;
        end else if (sum >= ACC_W'(LIMIT)) begin
            d.acc  = sum - ACC_W'(LIMIT);
            d.tick = 1'b1;
        end else begin
            d.acc  = sum;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

endmodule

// File: rtl/trk_parse.sv
module trk_parse
    import trk_pkg::*;
#(
    parameter int AW       = 8,
    parameter int CHANNELS = 14,
    parameter int PEND_W   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          play,
    input  logic          tick,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          ev_valid,
    input  logic          ev_ready,
    output trk_ev_t       ev,
    output logic          done,
    output logic          err,
    output logic          overrun
);
    localparam logic [NIB:0] CH_LIM = (NIB+1)'(CHANNELS);

    typedef struct packed {
        prs_state_t      st;
        logic [AW-1:0]   ptr;
        logic            head;
        logic            seen;
        logic [NIB-1:0]  last;
        logic [NIB-1:0]  chan;
        trk_ev_t         ev;
        logic [PEND_W-1:0] pend;
        logic            done;
        logic            err;
        logic            ovr;
    } prs_s;

    prs_s q, d;

    logic [NIB-1:0] op, lo;
    logic           parsing;
    logic           bad_ch;

    assign op = rd_data[7:4];
    assign lo = rd_data[3:0];

    always_comb begin
        d       = q;
        rd_en   = 1'b0;
        parsing = (q.st == S_FETCH) || (q.st == S_RECV) || (q.st == S_NFETCH) ||
                  (q.st == S_NRECV) || (q.st == S_EMIT);
        bad_ch  = ({1'b0, lo} >= CH_LIM) || (q.seen && (lo <= q.last));

        if (tick && parsing) begin
            d.ovr = 1'b1;
            if (q.pend != '1) d.pend = q.pend + 1'b1;
        end

        unique case (q.st)
            S_IDLE: begin
                d.st   = S_WAIT;
                d.ptr  = '0;
                d.head = 1'b1;
            end
            S_WAIT: begin
                if (tick || (q.pend != '0)) begin
                    d.st = S_FETCH;
                    if (!tick) d.pend = q.pend - 1'b1;
                end
            end
            S_FETCH: begin
                rd_en = 1'b1;
                d.st  = S_RECV;
            end
            S_RECV: begin
                if (q.head) begin
                    if (op == OP_MARK) begin
                        d.head = 1'b0;
                        d.seen = 1'b0;
                        d.ptr  = q.ptr + 1'b1;
                        d.st   = S_FETCH;
                    end else if (op == OP_END) begin
                        d.done = 1'b1;
                        d.st   = S_STOP;
                    end else begin
                        d.err = 1'b1;
                        d.st  = S_STOP;
                    end
                end else if (op == OP_MARK) begin
                    d.head = 1'b1;
                    d.st   = S_WAIT;
                end else if (op == OP_END) begin
                    d.done = 1'b1;
                    d.st   = S_STOP;
                end else if ((op == OP_ON) && !bad_ch) begin
                    d.chan = lo;
                    d.ptr  = q.ptr + 1'b1;
                    d.st   = S_NFETCH;
                end else if ((op == OP_OFF) && !bad_ch) begin
                    d.ev   = '{on: 1'b0, chan: lo, note: 3'd0, oct: 3'd0};
                    d.seen = 1'b1;
                    d.last = lo;
                    d.ptr  = q.ptr + 1'b1;
                    d.st   = S_EMIT;
                end else begin
                    d.err = 1'b1;
                    d.st  = S_STOP;
                end
            end
            S_NFETCH: begin
                rd_en = 1'b1;
                d.st  = S_NRECV;
            end
            S_NRECV: begin
                if ((op == '0) || (op > NOTE_MAX) || (lo > OCT_MAX)) begin
                    d.err = 1'b1;
                    d.st  = S_STOP;
                end else begin
                    d.ev   = '{on: 1'b1, chan: q.chan, note: op[2:0], oct: lo[2:0]};
                    d.seen = 1'b1;
                    d.last = q.chan;
                    d.ptr  = q.ptr + 1'b1;
                    d.st   = S_EMIT;
                end
            end
            S_EMIT: begin
                if (ev_ready) d.st = S_FETCH;
            end
            default: begin
                d.st = S_STOP;
            end
        endcase

        if (!play) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr  = q.ptr;
    assign ev_valid = (q.st == S_EMIT);
    assign ev       = q.ev;
    assign done     = q.done;
    assign err      = q.err;
    assign overrun  = q.ovr;

endmodule

// File: rtl/trk_seq.sv
module trk_seq
    import trk_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int BPM_W    = 9,
    parameter int AW       = 8,
    parameter int CHANNELS = 14,
    parameter int PEND_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             play,
    input  logic [BPM_W-1:0] tempo_bpm,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [7:0]       rd_data,
    output logic             ev_valid,
    input  logic             ev_ready,
    output logic             ev_on,
    output logic [3:0]       ev_chan,
    output logic [2:0]       ev_note,
    output logic [2:0]       ev_oct,
    output logic             tick,
    output logic             done,
    output logic             err,
    output logic             overrun
);
    trk_ev_t ev;

    trk_tempo #(
        .CLK_HZ (CLK_HZ),
        .BPM_W  (BPM_W)
    ) u_tempo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (play),
        .bpm   (tempo_bpm),
        .tick  (tick)
    );

    trk_parse #(
        .AW       (AW),
        .CHANNELS (CHANNELS),
        .PEND_W   (PEND_W)
    ) u_parse (
        .clk      (clk),
        .rst_n    (rst_n),
        .play     (play),
        .tick     (tick),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ev_valid (ev_valid),
        .ev_ready (ev_ready),
        .ev       (ev),
        .done     (done),
        .err      (err),
        .overrun  (overrun)
    );

    assign ev_on   = ev.on;
    assign ev_chan = ev.chan;
    assign ev_note = ev.note;
    assign ev_oct  = ev.oct;

endmodule

// File: rtl/trk_seq_chk.sv
module trk_seq_chk #(
    parameter int CHANNELS = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic       play,
    input logic       rd_en,
    input logic       ev_valid,
    input logic       ev_ready,
    input logic       ev_on,
    input logic [3:0] ev_chan,
    input logic [2:0] ev_note,
    input logic [2:0] ev_oct,
    input logic       tick,
    input logic       done,
    input logic       err,
    input logic       overrun
);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !play |=> (!ev_valid && !rd_en && !tick && !done && !err && !overrun));

    assert_chan_R4: assert property (@(posedge clk) disable iff (!rst_n || !play)
        ev_valid |-> ({1'b0, ev_chan} < 5'(CHANNELS)));

    assert_note_R4: assert property (@(posedge clk) disable iff (!rst_n || !play)
        (ev_valid && ev_on) |-> (ev_note != 3'd0));

    assert_offz_R5: assert property (@(posedge clk) disable iff (!rst_n || !play)
        (ev_valid && !ev_on) |-> (ev_note == 3'd0 && ev_oct == 3'd0));

    assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n || !play)
        done |=> (done && !ev_valid && !rd_en));

    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n || !play)
        err |=> (err && !ev_valid && !rd_en));

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !play)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable({ev_on, ev_chan, ev_note, ev_oct})));

    assert_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !rd_en);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n || !play)
        overrun |=> overrun);

endmodule

bind trk_seq trk_seq_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .play     (play),
    .rd_en    (rd_en),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .ev_on    (ev_on),
    .ev_chan  (ev_chan),
    .ev_note  (ev_note),
    .ev_oct   (ev_oct),
    .tick     (tick),
    .done     (done),
    .err      (err),
    .overrun  (overrun)
);

// File: tb/trk_seq_test.sv
module trk_seq_test;
    localparam int CLK_HZ = 100;
    localparam int BPM_W  = 9;
    localparam int AW     = 8;
    localparam int NCH    = 14;
    localparam int PEND_W = 4;
    localparam longint LIM = 60 * CLK_HZ;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             play = 1'b0;
    logic [BPM_W-1:0] tempo_bpm = '0;
    logic             rd_en;
    logic [AW-1:0]    rd_addr;
    logic [7:0]       rd_data = 8'h00;
    logic             ev_valid;
    logic             ev_ready = 1'b0;
    logic             ev_on;
    logic [3:0]       ev_chan;
    logic [2:0]       ev_note;
    logic [2:0]       ev_oct;
    logic             tick;
    logic             done;
    logic             err;
    logic             overrun;

    always #10 clk = ~clk;

    trk_seq #(
        .CLK_HZ(CLK_HZ), .BPM_W(BPM_W), .AW(AW), .CHANNELS(NCH), .PEND_W(PEND_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .play(play), .tempo_bpm(tempo_bpm),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_on(ev_on),
        .ev_chan(ev_chan), .ev_note(ev_note), .ev_oct(ev_oct),
        .tick(tick), .done(done), .err(err), .overrun(overrun)
    );

    logic [7:0] mem [0:255];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    typedef struct {
        bit on;
        int ch;
        int note;
        int oct;
        int per;
    } xev_t;

    xev_t exq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   ticks_seen = 0;
    int   wp = 0;
    int   rmode = 0;
    bit   mon_on = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string msg);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // tempo reference model (R1)
    longint m_acc = 0;
    bit     m_tick = 0;
    always @(posedge clk) begin
        if (!rst_n || !play) begin
            m_acc  = 0;
            m_tick = 0;
        end else begin
            longint s;
            s      = m_acc + longint'(tempo_bpm) * 8;
            m_tick = (s >= LIM);
            m_acc  = m_tick ? s - LIM : s;
        end
    end

    // ready driver
    logic [7:0] lf = 8'h5A;
    initial forever begin
        @(posedge clk);
        #2;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        case (rmode)
            0: ev_ready = 1'b1;
            1: ev_ready = lf[0] | lf[1];
            default: ev_ready = 1'b0;
        endcase
    end

    // monitor, sampled at falling edge
    bit         prev_stall = 0;
    logic [10:0] prev_pl = '0;
    always @(negedge clk) begin
        if (rst_n && mon_on && !finished) begin
            check(tick === m_tick,
                  $sformatf("R1 tick act=%0b exp=%0b", tick, m_tick));
            if (tick) ticks_seen++;
            if (prev_stall)
                check(ev_valid && {ev_on, ev_chan, ev_note, ev_oct} == prev_pl,
                      $sformatf("R8 hold act=%0b/%h exp=1/%h", ev_valid,
                                {ev_on, ev_chan, ev_note, ev_oct}, prev_pl));
            if ((done || err) && rd_en)
                check(0, $sformatf("R6 R7 read after halt act=%0b exp=0", rd_en));
            if (ev_valid && ev_ready) begin
                if (exq.size() == 0) begin
                    check(0, $sformatf("R6 R7 unexpected event ch=%0d act=1 exp=0", ev_chan));
                end else begin
                    xev_t e;
                    e = exq.pop_front();
                    check(ev_on == e.on && int'(ev_chan) == e.ch &&
                          int'(ev_note) == e.note && int'(ev_oct) == e.oct,
                          $sformatf("%s event act=%0b/%0d/%0d/%0d exp=%0b/%0d/%0d/%0d",
                                    e.on ? "R4" : "R5", ev_on, ev_chan, ev_note, ev_oct,
                                    e.on, e.ch, e.note, e.oct));
                    check(e.per <= ticks_seen,
                          $sformatf("R3 early event period act_ticks=%0d exp>=%0d",
                                    ticks_seen, e.per));
                end
            end
            prev_stall = ev_valid && !ev_ready;
            prev_pl    = {ev_on, ev_chan, ev_note, ev_oct};
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wp = 0;
    endtask

    task automatic put(input logic [7:0] v);
        mem[wp] = v;
        wp++;
    endtask

    // behavioural score interpretation: st 1 done, 2 error; ep = ticks needed
    task automatic build_expect(output int st, output int ep);
        int pos, per, last, nt, oc;
        bit head;
        xev_t e;
        pos = 0; per = 0; last = -1; head = 1; st = 0; ep = 0;
        exq.delete();
        for (int g = 0; g < 300 && st == 0; g++) begin
            int b, op, ch;
            b  = int'(mem[pos % 256]);
            op = b >> 4;
            ch = b & 15;
            if (head) begin
                if (op == 15) begin per++; head = 0; last = -1; pos++; end
                else begin st = (op == 12) ? 1 : 2; ep = per + 1; end
            end else if (op == 15) begin
                head = 1;
            end else if (op == 12) begin
                st = 1; ep = per;
            end else if (op == 13 || op == 14) begin
                if (ch >= NCH || ch <= last) begin
                    st = 2; ep = per;
                end else if (op == 13) begin
                    e = '{0, ch, 0, 0, per};
                    exq.push_back(e);
                    last = ch; pos++;
                end else begin
                    nt = int'(mem[(pos + 1) % 256]) >> 4;
                    oc = int'(mem[(pos + 1) % 256]) & 15;
                    if (nt == 0 || nt > 7 || oc > 7) begin
                        st = 2; ep = per;
                    end else begin
                        e = '{1, ch, nt, oc, per};
                        exq.push_back(e);
                        last = ch; pos += 2;
                    end
                end
            end else begin
                st = 2; ep = per;
            end
        end
    endtask

    task automatic start_play(input int b);
        @(posedge clk);
        #2;
        tempo_bpm  = BPM_W'(b);
        ticks_seen = 0;
        play       = 1'b1;
    endtask

    task automatic wait_end(input int maxc);
        for (int i = 0; i < maxc && !(done || err); i++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic stop_and_check_idle(input string tag);
        @(posedge clk);
        #2;
        play = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!ev_valid && !rd_en && !done && !err && !overrun,
              $sformatf("R2 %s idle act=%0b%0b%0b%0b%0b exp=00000", tag,
                        ev_valid, rd_en, done, err, overrun));
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_check(input int st, input int ep, input string tag,
                                input bit chk_ovr, input bit exp_ovr);
        bit xd, xe;
        int miss;
        xd = (st == 1) && (ticks_seen >= ep);
        xe = (st == 2) && (ticks_seen >= ep);
        check(done == xd, $sformatf("R6 %s done act=%0b exp=%0b", tag, done, xd));
        check(err == xe, $sformatf("R7 %s err act=%0b exp=%0b", tag, err, xe));
        miss = 0;
        foreach (exq[i]) if (exq[i].per <= ticks_seen) miss++;
        check(miss == 0, $sformatf("R3 R9 %s undelivered act=%0d exp=0", tag, miss));
        if (chk_ovr)
            check(overrun == exp_ovr,
                  $sformatf("R9 %s overrun act=%0b exp=%0b", tag, overrun, exp_ovr));
        stop_and_check_idle(tag);
    endtask

    task automatic song_a();
        clear_mem();
        put(8'hF0); put(8'hE0); put(8'h47); put(8'hE3); put(8'h15); put(8'hDD);
        put(8'hF5);
        put(8'hF0); put(8'hD0); put(8'hD3); put(8'hED); put(8'h70);
        put(8'hF7); put(8'hE5); put(8'h12);
        put(8'hF0); put(8'hD5); put(8'hC0);
    endtask

    task automatic run_simple(input int b, input int rm, input string tag,
                              input bit chk_ovr, input bit exp_ovr);
        int st, ep;
        build_expect(st, ep);
        rmode = rm;
        start_play(b);
        wait_end(3000);
        finish_check(st, ep, tag, chk_ovr, exp_ovr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int st, ep;
        clear_mem();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!ev_valid && !rd_en && !tick && !done && !err && !overrun,
              $sformatf("R2 reset state act=%0b%0b%0b%0b%0b%0b exp=000000",
                        ev_valid, rd_en, tick, done, err, overrun));
        @(posedge clk);
        #2;
        rst_n  = 1'b1;
        mon_on = 1;
        repeat (5) @(negedge clk);
        check(!tick && !rd_en, "R2 no activity while play low");

        // R3 R4 R5 R6 slow tempo, always ready: no overrun
        song_a();
        run_simple(10, 0, "slow", 1, 0);

        // R8 fast tempo with random readiness
        song_a();
        run_simple(60, 1, "random-ready", 0, 0);

        // R9 stall: ticks queued while ready low, then tempo stopped
        clear_mem();
        for (int k = 0; k < 10; k++) begin
            put(8'hF0);
            put(8'hD0 | 8'(k % NCH));
        end
        put(8'hC0);
        build_expect(st, ep);
        rmode = 2;
        start_play(100);
        repeat (40) @(posedge clk);
        #2;
        tempo_bpm = '0;
        repeat (3) @(posedge clk);
        rmode = 0;
        repeat (200) @(negedge clk);
        check(ticks_seen >= 2 && ticks_seen < 10,
              $sformatf("R9 stall tick count act=%0d exp=2..9", ticks_seen));
        finish_check(st, ep, "stall", 1, 1);

        // R7 malformed streams
        clear_mem(); put(8'hF0); put(8'hE2); put(8'h31); put(8'h52);
        run_simple(60, 0, "bad-op", 0, 0);
        clear_mem(); put(8'hF0); put(8'hEE); put(8'h11);
        run_simple(60, 0, "chan14", 0, 0);
        clear_mem(); put(8'hF0); put(8'hE1); put(8'h05);
        run_simple(60, 0, "note0", 0, 0);
        clear_mem(); put(8'hF0); put(8'hE1); put(8'h85);
        run_simple(60, 0, "note8", 0, 0);
        clear_mem(); put(8'hF0); put(8'hE1); put(8'h19);
        run_simple(60, 0, "oct9", 0, 0);
        clear_mem(); put(8'hF0); put(8'hD4); put(8'hD2);
        run_simple(60, 0, "descending", 0, 0);
        clear_mem(); put(8'hF0); put(8'hD4); put(8'hF0); put(8'hD4); put(8'hD4);
        run_simple(60, 0, "repeat-chan", 0, 0);
        clear_mem(); put(8'hD1); put(8'hF0);
        run_simple(60, 0, "no-marker", 0, 0);

        // R6 end marker at the very start
        clear_mem(); put(8'hC3);
        run_simple(60, 0, "empty-song", 0, 0);

        // R2 abort mid-song, then restart from address 0
        song_a();
        build_expect(st, ep);
        rmode = 0;
        start_play(60);
        repeat (30) @(negedge clk);
        stop_and_check_idle("abort");
        song_a();
        run_simple(60, 0, "restart", 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule